// File: doc/BRIEF.md
# Looping Time-Step Sequencer

This block produces the step index that a stepped execution engine uses to choose its resources for each step, such as an instruction store, an arithmetic variant or a register window. After a start, the index counts 1, 2, … up to a programmed length L. From then on it cycles through k+1 … L over and over, so a prologue is followed by a body that repeats. It moves forward one step for each advance pulse. It freezes when told to stop.

Each step owns an entry in an internal table. The entry holds a load-possible flag, a store-possible flag and a mask of the registers that step may touch. The block presents the entry of the current step on its outputs. From the two flags it derives a skip signal, which lets the datapath bypass the memory stage when no load or store can happen in that step.

Software writes the length L, the loop point k and the table entries while the sequencer is idle. A pair (L, k) that cannot describe a schedule is refused and flagged.

Top module: `step_sched`

## Requirements
- R1: After reset the block is idle (`idle`=1), `step`=0, `cfg_err`=0, `mem_skip`=1 and `reg_mask`=0.
- R2: While idle, a `cfg_we` cycle with 1 ≤ `cfg_len` ≤ DEPTH and `cfg_loop` < `cfg_len` stores L=`cfg_len` and k=`cfg_loop`, and it clears `cfg_err` on the next cycle.
- R3: While idle, a `cfg_we` cycle with `cfg_loop` ≥ `cfg_len`, `cfg_len`=0 or `cfg_len` > DEPTH sets `cfg_err` on the next cycle. The previously stored L and k are kept.
- R4: While running, `cfg_we` and `tbl_we` have no effect: the schedule and the table outputs stay as before.
- R5: A `start` pulse while idle with a valid stored configuration makes `step`=1 and `idle`=0 on the next cycle. A `start` with no valid configuration leaves the block idle.
- R6: While running, an `adv` pulse with `step` < L makes `step` increase by one on the next cycle. Without `adv`, `step` holds.
- R7: While running, an `adv` pulse with `step` = L makes `step` = k+1 on the next cycle. This wrap applies for every k from 0 to L−1.
- R8: `stop` while running makes `idle`=1 on the next cycle and leaves `step` unchanged, even when `adv` is high in the same cycle.
- R9: While running, `ld_ok`, `st_ok` and `reg_mask` show table entry `step`−1 in the same cycle. An entry is written at address `tbl_addr` with `tbl_ld`, `tbl_st` and `tbl_mask`. While idle, these three outputs are 0.
- R10: `mem_skip` is 1 exactly when `ld_ok` and `st_ok` are both 0. It is therefore 1 whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write L and k (idle only) |
| cfg_len | input | 7 | Schedule length L |
| cfg_loop | input | 7 | Loop point k |
| tbl_we | input | 1 | Write one table entry (idle only) |
| tbl_addr | input | 6 | Entry index (step number minus one) |
| tbl_ld | input | 1 | Load-possible flag to write |
| tbl_st | input | 1 | Store-possible flag to write |
| tbl_mask | input | 32 | Register mask to write |
| start | input | 1 | Begin at step 1 |
| adv | input | 1 | One-cycle step-advance pulse |
| stop | input | 1 | Freeze and go idle |
| step | output | 7 | Current step number |
| idle | output | 1 | Sequencer is idle |
| cfg_err | output | 1 | Last configuration was refused |
| ld_ok | output | 1 | A load may occur in this step |
| st_ok | output | 1 | A store may occur in this step |
| reg_mask | output | 32 | Registers this step may access |
| mem_skip | output | 1 | Memory stage may be bypassed |

## Verification
The bench uses the default DEPTH of 64 and 32 registers. At these values the full-depth schedule L=64 can be run, and the bench can try lengths just past the table size (65) and a length of zero to show they are refused. The wrap from L to k+1 is exercised with k=0, k=L−1, a middle k and a long L=64 body. The table contents are chosen so that the two flags appear in every combination, which drives `mem_skip` both high and low during a run.

// File: rtl/step_sched.sv
module step_sched #(
  parameter int DEPTH = 64,
  parameter int NREG  = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int SW   = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [SW-1:0]   cfg_len,
  input  logic [SW-1:0]   cfg_loop,
  input  logic            tbl_we,
  input  logic [AW-1:0]   tbl_addr,
  input  logic            tbl_ld,
  input  logic            tbl_st,
  input  logic [NREG-1:0] tbl_mask,
  input  logic            start,
  input  logic            adv,
  input  logic            stop,
  output logic [SW-1:0]   step,
  output logic            idle,
  output logic            cfg_err,
  output logic            ld_ok,
  output logic            st_ok,
  output logic [NREG-1:0] reg_mask,
  output logic            mem_skip
);

  logic [NREG+1:0] tbl [DEPTH];
  logic [SW-1:0]   step_q, len_q, loop_q, idx;
  logic            idle_q, valid_q, err_q;
  logic            cfg_bad, go, at_end;
  logic [NREG+1:0] ent;

  assign cfg_bad = (cfg_len == '0) || (cfg_len > SW'(DEPTH)) || (cfg_loop >= cfg_len);
  assign go      = !idle_q && adv && !stop;
  assign at_end  = (step_q == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q  <= 1'b1;
      step_q  <= '0;
      len_q   <= '0;
      loop_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (idle_q) begin
      if (cfg_we) begin
        err_q <= cfg_bad;
        if (!cfg_bad) begin
          len_q   <= cfg_len;
          loop_q  <= cfg_loop;
          valid_q <= 1'b1;
        end
      end else if (start && valid_q) begin
        idle_q <= 1'b0;
        step_q <= SW'(1);
      end
    end else if (stop) begin
      idle_q <= 1'b1;
    end else if (go) begin
      step_q <= at_end ? loop_q + 1'b1 : step_q + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (tbl_we && idle_q) tbl[tbl_addr] <= {tbl_ld, tbl_st, tbl_mask};

  assign idx = step_q - 1'b1;
  assign ent = idle_q ? '0 : tbl[idx[AW-1:0]];

  assign step     = step_q;
  assign idle     = idle_q;
  assign cfg_err  = err_q;
  assign ld_ok    = ent[NREG+1];
  assign st_ok    = ent[NREG];
  assign reg_mask = ent[NREG-1:0];
  assign mem_skip = !(ld_ok || st_ok);

endmodule

// File: rtl/step_sched_chk.sv
module step_sched_chk #(
  parameter int SW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          idle,
  input logic [SW-1:0] step,
  input logic          adv,
  input logic          stop,
  input logic          cfg_we,
  input logic [SW-1:0] cfg_len,
  input logic [SW-1:0] cfg_loop,
  input logic          cfg_err,
  input logic [SW-1:0] len_q,
  input logic [SW-1:0] loop_q
);

  // R6
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && adv && !stop && step != len_q) |=> (step == $past(step) + 1'b1));

  // R7
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && adv && !stop && step == len_q) |=> (step == $past(loop_q) + 1'b1));

  // R8
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && stop) |=> (idle && $stable(step)));

  // R3
  cfg_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cfg_we && cfg_loop >= cfg_len) |=> cfg_err);

  // R5
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (step >= 1 && step <= len_q));

endmodule

bind step_sched step_sched_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle(idle), .step(step), .adv(adv), .stop(stop),
  .cfg_we(cfg_we), .cfg_len(cfg_len), .cfg_loop(cfg_loop), .cfg_err(cfg_err),
  .len_q(len_q), .loop_q(loop_q)
);

// File: tb/tb_step_sched.sv
module tb_step_sched;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 0, tbl_we = 0, tbl_ld = 0, tbl_st = 0, start = 0, adv = 0, stop = 0;
  logic [6:0]  cfg_len = 0, cfg_loop = 0;
  logic [5:0]  tbl_addr = 0;
  logic [31:0] tbl_mask = 0;
  logic [6:0]  step;
  logic        idle, cfg_err, ld_ok, st_ok, mem_skip;
  logic [31:0] reg_mask;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  step_sched dut (.*);

  function automatic logic ld_of(int i);  return (i % 3) == 0; endfunction
  function automatic logic st_of(int i);  return (i % 5) == 0; endfunction
  function automatic logic [31:0] mk_of(int i);
    return (32'h1 << (i % 32)) | (32'h8000_0000 >> (i % 7));
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
    cfg_we = 0; tbl_we = 0; start = 0; adv = 0; stop = 0;
  endtask

  task automatic settle; @(negedge clk); endtask

  task automatic do_cfg(input int l, input int k);
    cfg_len = 7'(l); cfg_loop = 7'(k); cfg_we = 1; tick(); settle();
  endtask

  task automatic do_start; start = 1; tick(); settle(); endtask

  task automatic check_entry(input int s, input string tag);
    chk(ld_ok == ld_of(s-1), {tag, " R9 ld"}, ld_ok, ld_of(s-1));
    chk(st_ok == st_of(s-1), {tag, " R9 st"}, st_ok, st_of(s-1));
    chk(reg_mask == mk_of(s-1), {tag, " R9 mask"}, reg_mask, mk_of(s-1));
    chk(mem_skip == !(ld_of(s-1) || st_of(s-1)), {tag, " R10 skip"}, mem_skip,
        !(ld_of(s-1) || st_of(s-1)));
  endtask

  task automatic t_reset;
    settle();
    chk(idle == 1, "R1 idle", idle, 1);
    chk(step == 0, "R1 step", step, 0);
    chk(cfg_err == 0, "R1 err", cfg_err, 0);
    chk(mem_skip == 1, "R1 R10 skip", mem_skip, 1);
    chk(reg_mask == 0, "R1 R9 mask", reg_mask, 0);
  endtask

  task automatic fill_table;
    for (int i = 0; i < 64; i++) begin
      tbl_addr = 6'(i); tbl_ld = ld_of(i); tbl_st = st_of(i); tbl_mask = mk_of(i);
      tbl_we = 1; tick();
    end
    settle();
  endtask

  task automatic t_badcfg;
    do_cfg(5, 5);
    chk(cfg_err == 1, "R3 k=L", cfg_err, 1);
    do_start();
    chk(idle == 1, "R5 start without config", idle, 1);
    do_cfg(0, 0);
    chk(cfg_err == 1, "R3 L=0", cfg_err, 1);
    do_cfg(65, 2);
    chk(cfg_err == 1, "R3 L>DEPTH", cfg_err, 1);
  endtask

  task automatic t_wrap(input int l, input int k, input int n, input string tag);
    int e;
    do_cfg(l, k);
    chk(cfg_err == 0, {tag, " R2 accept"}, cfg_err, 0);
    do_start();
    chk(idle == 0 && step == 1, {tag, " R5 first step"}, step, 1);
    check_entry(1, tag);
    e = 1;
    for (int i = 0; i < n; i++) begin
      adv = 1; tick(); settle();
      e = (e == l) ? k + 1 : e + 1;
      chk(step == 7'(e), {tag, " R6 R7 step"}, step, e);
      if (i % 7 == 0) check_entry(e, tag);
    end
    stop = 1; tick(); settle();
  endtask

  task automatic t_hold_stop;
    int s;
    do_cfg(6, 2); do_start();
    adv = 1; tick(); adv = 1; tick(); settle();
    s = step;
    tick(); tick(); settle();
    chk(step == 7'(s), "R6 hold without adv", step, s);
    adv = 1; stop = 1; tick(); settle();
    chk(idle == 1, "R8 idle", idle, 1);
    chk(step == 7'(s), "R8 frozen", step, s);
    chk(reg_mask == 0 && mem_skip == 1, "R9 R10 idle outputs", reg_mask, 0);
  endtask

  task automatic t_run_ignore;
    do_cfg(3, 1); do_start();
    cfg_len = 7'd10; cfg_loop = 7'd0; cfg_we = 1; tick();
    tbl_addr = 6'd1; tbl_ld = ~ld_of(1); tbl_st = ~st_of(1); tbl_mask = 32'h0; tbl_we = 1; tick();
    adv = 1; tick(); settle();
    chk(step == 2, "R4 step", step, 2);
    check_entry(2, "R4");
    adv = 1; tick(); adv = 1; tick(); settle();
    chk(step == 2, "R4 R7 old wrap kept", step, 2);
    stop = 1; tick(); settle();
  endtask

  initial begin
    #200000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    #12 rst_n = 1;
    fill_table();
    t_badcfg();
    t_wrap(4, 0, 20, "k0");
    t_wrap(5, 4, 20, "kLm1");
    t_wrap(8, 3, 40, "kmid");
    t_wrap(64, 10, 200, "L64");
    t_hold_stop();
    t_run_ignore();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule